// File: doc/BRIEF.md
# Direct Register-Pair Load/Store Sequencer

This block is a small fragment of an 8-bit processor core. It runs only two three-byte instructions. One fills the 16-bit register pair H:L from two consecutive memory bytes at a direct address. The other writes the pair back to two consecutive bytes. The operand address is carried little-endian in the two bytes after the opcode. The low register, L, always goes with the operand address and the high register, H, with the next address.

The block drives a plain synchronous memory bus with one clock per T-state. Every instruction follows a fixed machine-cycle plan: an opcode fetch of four T-states, then two address-byte reads and two data transfers of three T-states each, for 16 clocks in all. The read or write strobe is high for exactly one clock, in the second T-state of each machine cycle. Read data is taken at the clock edge that ends that T-state, and a write is committed by the memory at that same edge. Any opcode other than the two recognised ones is treated as a one-byte no-operation. A flag register is present but neither instruction touches it. A one-clock completion pulse lets the surrounding logic check the register and memory state.

Top module: `pairmv_core`

## Requirements
- R1: The opcode byte is read from address PC. The value 0x2A selects the pair load and 0x22 selects the pair store. Any other value is a one-byte no-operation that takes only the 4-T-state fetch.
- R2: Bytes two and three of an instruction give the low and high halves of the operand address. PC goes up by one at each byte read, so it advances by 3 per load/store and by 1 per no-operation. PC wraps modulo 2^16.
- R3: The load puts the byte at the operand address into L and the byte at the operand address plus one into H. It issues no write strobe.
- R4: The store writes L to the operand address and then H to the operand address plus one. H and L keep their values.
- R5: The operand address plus one wraps modulo 2^16, so 0xFFFF is followed by 0x0000. This applies to both load and store.
- R6: The flag output holds its reset value (0x02 by default) at all times.
- R7: A load or store takes 16 clocks and a no-operation takes 4. Each machine cycle gives exactly one single-clock strobe. A load gives 5 reads and no writes; a store gives 3 reads then 2 writes. The read and write strobes are never high together.
- R8: `instr_done` is high for one clock, in the clock right after the last T-state of each instruction. At that time H, L, PC and memory already show the finished instruction.
- R9: While reset is low, PC equals RESET_PC (0x0000 by default), H and L are 0x00, both strobes are low and `instr_done` is low. The first opcode fetch starts once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one period per T-state |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address for the current machine cycle |
| mem_rd | output | 1 | Read strobe, one clock per read machine cycle |
| mem_wr | output | 1 | Write strobe, one clock per write machine cycle |
| mem_wdata | output | 8 | Data to be written while mem_wr is high |
| mem_rdata | input | 8 | Read data, sampled at the edge ending the read strobe |
| pc | output | 16 | Program counter |
| reg_h | output | 8 | High register of the pair |
| reg_l | output | 8 | Low register of the pair |
| flags | output | 8 | Flag register, never modified |
| instr_done | output | 1 | One-clock pulse after each instruction |

## Verification
Two events share one clock: the completion pulse and the first T-state of the next opcode fetch. The completion pulse reports on the finished instruction, while the next fetch already drives PC onto the bus. The bench runs instructions back to back with no gaps and checks PC, H, L, memory and the per-instruction strobe counts in the cycle after each pulse. It also checks the spacing between pulses, so a fetch that slips by one clock shows up. In a second overlap, a store to 0xFFFF writes its high byte over program address 0x0000, which has already been fetched. A later load from 0xFFFF must then read back that overwritten byte.

// File: rtl/pairmv_pkg.sv
// Shared types for the register-pair load/store sequencer.
// Assumes: 8-bit data, opcode values fixed by the instruction encoding.
package pairmv_pkg;

    // Machine cycles of one instruction, in bus order.
    typedef enum logic [2:0] {
        MC_FETCH = 3'd0,
        MC_ADRLO = 3'd1,
        MC_ADRHI = 3'd2,
        MC_DAT0  = 3'd3,
        MC_DAT1  = 3'd4
    } mcyc_e;

    // Decoded instruction class.
    typedef enum logic [1:0] {
        OPK_NOP   = 2'd0,
        OPK_LOAD  = 2'd1,
        OPK_STORE = 2'd2
    } opkind_e;

    localparam logic [7:0] OPC_PAIR_LOAD  = 8'h2A;
    localparam logic [7:0] OPC_PAIR_STORE = 8'h22;

    // Map an opcode byte to its class; anything unknown is a no-operation.
    function automatic opkind_e op_decode(input logic [7:0] op);
        case (op)
            OPC_PAIR_LOAD:  return OPK_LOAD;
            OPC_PAIR_STORE: return OPK_STORE;
            default:        return OPK_NOP;
        endcase
    endfunction

endpackage

// File: rtl/pairmv_seq.sv
// T-state and machine-cycle sequencer.
// Steps through fetch (FETCH_T states), then four machine cycles of MC_T
// states for load/store, or straight back to fetch for a no-operation.
// Assumes: `kind` is valid from the T-state after the fetch strobe onward.
module pairmv_seq
    import pairmv_pkg::*;
#(
    parameter int FETCH_T = 4,
    parameter int MC_T    = 3,
    parameter int TW      = $clog2(FETCH_T)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  opkind_e       kind,
    output mcyc_e         mc,
    output logic [TW-1:0] tst,
    output logic          last_t,
    output logic          done
);

    localparam logic [TW-1:0] FETCH_LAST = TW'(FETCH_T - 1);
    localparam logic [TW-1:0] MC_LAST    = TW'(MC_T - 1);

    // Flag the final T-state of the current machine cycle.
    always_comb begin
        last_t = (mc == MC_FETCH) ? (tst == FETCH_LAST) : (tst == MC_LAST);
    end

    // Advance T-state, pick the next machine cycle, raise the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc   <= MC_FETCH;
            tst  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (last_t) begin
                tst <= '0;
                case (mc)
                    MC_FETCH: begin
                        if (kind == OPK_NOP) begin
                            mc   <= MC_FETCH;
                            done <= 1'b1;
                        end else begin
                            mc <= MC_ADRLO;
                        end
                    end
                    MC_ADRLO: mc <= MC_ADRHI;
                    MC_ADRHI: mc <= MC_DAT0;
                    MC_DAT0:  mc <= MC_DAT1;
                    default: begin
                        mc   <= MC_FETCH;
                        done <= 1'b1;
                    end
                endcase
            end else begin
                tst <= tst + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pairmv_regs.sv
// Architectural state: program counter, instruction byte, operand address,
// the H/L pair and the flag register.
// Assumes: `take` is high for exactly one clock per read machine cycle,
// and read data is valid in that clock.
module pairmv_regs
    import pairmv_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          AW        = 2 * DW,
    parameter logic [AW-1:0] RESET_PC  = '0,
    parameter logic [DW-1:0] FLAG_INIT = 8'h02
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mcyc_e         mc,
    input  opkind_e       kind,
    input  logic          take,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] opaddr,
    output logic [DW-1:0] reg_h,
    output logic [DW-1:0] reg_l,
    output logic [DW-1:0] flags
);

    logic [DW-1:0] op_lo;
    logic [DW-1:0] op_hi;

    // Little-endian operand address from the two captured bytes.
    assign opaddr = {op_hi, op_lo};

    // Capture fetched bytes, step the PC, and load the pair on load reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            ir    <= '0;
            op_lo <= '0;
            op_hi <= '0;
            reg_h <= '0;
            reg_l <= '0;
        end else if (take) begin
            case (mc)
                MC_FETCH: begin
                    ir <= rdata;
                    pc <= pc + 1'b1;
                end
                MC_ADRLO: begin
                    op_lo <= rdata;
                    pc    <= pc + 1'b1;
                end
                MC_ADRHI: begin
                    op_hi <= rdata;
                    pc    <= pc + 1'b1;
                end
                MC_DAT0: if (kind == OPK_LOAD) reg_l <= rdata;
                default: if (kind == OPK_LOAD) reg_h <= rdata;
            endcase
        end
    end

    // Flag register: set at reset, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= FLAG_INIT;
        else        flags <= flags;
    end

endmodule

// File: rtl/pairmv_bus.sv
// Bus driver: picks the address for each machine cycle and forms the
// one-clock read/write strobes in T-state STB_T.
// Assumes: the address only matters while a strobe is high.
module pairmv_bus
    import pairmv_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 2 * DW,
    parameter int TW    = 2,
    parameter int STB_T = 1
) (
    input  mcyc_e         mc,
    input  logic [TW-1:0] tst,
    input  opkind_e       kind,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] opaddr,
    input  logic [DW-1:0] reg_h,
    input  logic [DW-1:0] reg_l,
    output logic [AW-1:0] addr,
    output logic          rd,
    output logic          wr,
    output logic [DW-1:0] wdata
);

    localparam logic [TW-1:0] STB = TW'(STB_T);

    logic strobe_t;
    logic data_mc;

    // Strobe timing and data-phase detection.
    always_comb begin
        strobe_t = (tst == STB);
        data_mc  = (mc == MC_DAT0) || (mc == MC_DAT1);
        rd       = strobe_t && (!data_mc || (kind == OPK_LOAD));
        wr       = strobe_t && data_mc && (kind == OPK_STORE);
    end

    // Address and write data per machine cycle; high byte wraps at +1.
    always_comb begin
        case (mc)
            MC_DAT0: addr = opaddr;
            MC_DAT1: addr = opaddr + 1'b1;
            default: addr = pc;
        endcase
        wdata = (mc == MC_DAT1) ? reg_h : reg_l;
    end

endmodule

// File: rtl/pairmv_core.sv
// Top of the register-pair load/store sequencer.
// Runs the pair-load (0x2A) and pair-store (0x22) instructions over a
// synchronous one-clock-per-T-state bus; other opcodes are no-operations.
// Assumes: memory returns read data combinationally in the strobe clock
// and commits writes at the edge that ends the write strobe.
module pairmv_core
    import pairmv_pkg::*;
#(
    parameter int            DW        = 8,
    parameter int            AW        = 2 * DW,
    parameter int            FETCH_T   = 4,
    parameter int            MC_T      = 3,
    parameter int            STB_T     = 1,
    parameter logic [AW-1:0] RESET_PC  = '0,
    parameter logic [DW-1:0] FLAG_INIT = 8'h02
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] reg_h,
    output logic [DW-1:0] reg_l,
    output logic [DW-1:0] flags,
    output logic          instr_done
);

    localparam int TW = $clog2(FETCH_T);

    mcyc_e         mc;
    logic [TW-1:0] tst;
    logic          last_t;
    logic [DW-1:0] ir;
    logic [AW-1:0] opaddr;
    opkind_e       kind;

    // Instruction class from the held opcode byte.
    assign kind = op_decode(ir);

    pairmv_seq #(
        .FETCH_T (FETCH_T),
        .MC_T    (MC_T),
        .TW      (TW)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .mc     (mc),
        .tst    (tst),
        .last_t (last_t),
        .done   (instr_done)
    );

    pairmv_regs #(
        .DW        (DW),
        .AW        (AW),
        .RESET_PC  (RESET_PC),
        .FLAG_INIT (FLAG_INIT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mc     (mc),
        .kind   (kind),
        .take   (mem_rd),
        .rdata  (mem_rdata),
        .pc     (pc),
        .ir     (ir),
        .opaddr (opaddr),
        .reg_h  (reg_h),
        .reg_l  (reg_l),
        .flags  (flags)
    );

    pairmv_bus #(
        .DW    (DW),
        .AW    (AW),
        .TW    (TW),
        .STB_T (STB_T)
    ) u_bus (
        .mc     (mc),
        .tst    (tst),
        .kind   (kind),
        .pc     (pc),
        .opaddr (opaddr),
        .reg_h  (reg_h),
        .reg_l  (reg_l),
        .addr   (mem_addr),
        .rd     (mem_rd),
        .wr     (mem_wr),
        .wdata  (mem_wdata)
    );

endmodule

// File: rtl/pairmv_chk.sv
// Protocol checker for pairmv_core, attached by bind below.
// Assumes: the default geometry of 3-T-state data machine cycles.
module pairmv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [15:0] pc,
    input logic [7:0]  reg_h,
    input logic [7:0]  reg_l,
    input logic        instr_done
);

    // R7: a read strobe lasts a single clock
    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R7: a write strobe lasts a single clock
    p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R7: read and write never together
    p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8: completion pulse is one clock wide
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    // R4: a store write leaves the pair untouched
    p_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ($stable(reg_h) && $stable(reg_l)));

    // R5: second write of a store goes to the first address plus one, wrapping
    p_pair_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr, 3)) |-> (mem_addr == $past(mem_addr, 3) + 16'd1));

    // R2: the PC only ever moves by +1
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> (pc == $past(pc) + 16'd1));

endmodule

bind pairmv_core pairmv_chk u_chk (.*);

// File: tb/sim_pairmv_core.sv
`timescale 1ns/1ps
module sim_pairmv_core;

    localparam int CLK_HALF = 10;   // 50 MHz
    localparam int MAX_CYC  = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst1_n = 1'b0;
    always #(CLK_HALF) clk = ~clk;

    // Sparse memory: 1024 bytes indexed by {addr[15], addr[8:0]}.
    logic [7:0] mem [1024];
    function automatic logic [9:0] mix(input logic [15:0] a);
        return {a[15], a[8:0]};
    endfunction

    logic [15:0] mem_addr, pc, mem_addr1, pc1;
    logic        mem_rd, mem_wr, instr_done, mem_rd1, mem_wr1, done1;
    logic [7:0]  mem_wdata, mem_rdata, reg_h, reg_l, flags;
    logic [7:0]  mem_wdata1, mem_rdata1, reg_h1, reg_l1, flags1;

    assign mem_rdata  = mem[mix(mem_addr)];
    assign mem_rdata1 = mem[mix(mem_addr1)];

    pairmv_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc(pc), .reg_h(reg_h), .reg_l(reg_l), .flags(flags),
        .instr_done(instr_done)
    );

    // Second copy starting near the top of the address space (PC wrap).
    pairmv_core #(.RESET_PC(16'hFFFE)) u1 (
        .clk(clk), .rst_n(rst1_n), .mem_addr(mem_addr1), .mem_rd(mem_rd1),
        .mem_wr(mem_wr1), .mem_wdata(mem_wdata1), .mem_rdata(mem_rdata1),
        .pc(pc1), .reg_h(reg_h1), .reg_l(reg_l1), .flags(flags1),
        .instr_done(done1)
    );

    // Memory write port for u0 only.
    always @(posedge clk) if (rst_n && mem_wr) mem[mix(mem_addr)] <= mem_wdata;

    // Per-instruction strobe and length counters for u0.
    int rd_cnt, wr_cnt, len_cnt, last_rd, last_wr, last_len;
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0; wr_cnt <= 0; len_cnt <= 0;
        end else if (instr_done) begin
            last_rd <= rd_cnt; last_wr <= wr_cnt; last_len <= len_cnt;
            rd_cnt <= 0; wr_cnt <= 0; len_cnt <= 1;
        end else begin
            rd_cnt  <= rd_cnt + int'(mem_rd);
            wr_cnt  <= wr_cnt + int'(mem_wr);
            len_cnt <= len_cnt + 1;
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input bit which);
        bit seen = 0;
        for (int k = 0; k < 200 && !seen; k++) begin
            @(negedge clk);
            seen = which ? done1 : instr_done;
        end
        total++;
        if (!seen) begin
            bad++;
            $display("FAIL R8 done pulse missing actual=0 expected=1");
        end
        @(negedge clk);   // counters and state settle one clock later
    endtask

    // Vector: {opcode, operand address, preload low byte, preload high byte}
    localparam int NV = 9;
    localparam logic [39:0] VEC [NV] = '{
        {8'h2A, 16'h1050, 8'h30, 8'h32},   // load
        {8'h22, 16'h8200, 8'h00, 8'h00},   // store
        {8'h00, 16'h0000, 8'h00, 8'h00},   // nop
        {8'h2A, 16'h8300, 8'hA5, 8'h5A},   // load
        {8'h22, 16'hFFFF, 8'h00, 8'h00},   // store, wraps to 0x0000
        {8'h2A, 16'h8040, 8'hFF, 8'h00},   // load
        {8'h7E, 16'h0000, 8'h00, 8'h00},   // unknown -> nop
        {8'h2A, 16'hFFFF, 8'h00, 8'h00},   // load, wraps to 0x0000
        {8'h22, 16'h1050, 8'h00, 8'h00}    // store over earlier data
    };

    initial begin
        logic [15:0] ppc;
        logic [15:0] exp_pc;
        logic [7:0]  exp_h, exp_l;
        for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
        ppc = 16'h0000;
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  op;
            logic [15:0] a;
            op = VEC[i][39:32];
            a  = VEC[i][31:16];
            mem[mix(ppc)] = op; ppc = ppc + 1;
            if (op == 8'h2A || op == 8'h22) begin
                mem[mix(ppc)] = a[7:0];  ppc = ppc + 1;
                mem[mix(ppc)] = a[15:8]; ppc = ppc + 1;
            end
            if (op == 8'h2A && a != 16'hFFFF) begin
                mem[mix(a)]         = VEC[i][15:8];
                mem[mix(a + 16'd1)] = VEC[i][7:0];
            end
        end

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 pc", 32'(pc), 32'h0000);
        chk("R9 h", 32'(reg_h), 32'h00);
        chk("R9 l", 32'(reg_l), 32'h00);
        chk("R9 strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk("R9 done", 32'(instr_done), 32'd0);
        chk("R6 flags at reset", 32'(flags), 32'h02);
        rst_n = 1'b1;

        exp_pc = 16'h0000; exp_h = 8'h00; exp_l = 8'h00;
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  op;
            logic [15:0] a;
            int er, ew, el;
            op = VEC[i][39:32];
            a  = VEC[i][31:16];
            if (op == 8'h2A) begin
                exp_l = mem[mix(a)]; exp_h = mem[mix(a + 16'd1)];
                exp_pc = exp_pc + 3; er = 5; ew = 0; el = 16;
            end else if (op == 8'h22) begin
                exp_pc = exp_pc + 3; er = 3; ew = 2; el = 16;
            end else begin
                exp_pc = exp_pc + 1; er = 1; ew = 0; el = 4;
            end
            wait_done(0);
            chk($sformatf("R2 pc vec%0d", i), 32'(pc), 32'(exp_pc));
            chk($sformatf("R3 l vec%0d", i), 32'(reg_l), 32'(exp_l));
            chk($sformatf("R3 h vec%0d", i), 32'(reg_h), 32'(exp_h));
            chk($sformatf("R6 flags vec%0d", i), 32'(flags), 32'h02);
            chk($sformatf("R7 reads vec%0d", i), 32'(last_rd), 32'(er));
            chk($sformatf("R7 writes vec%0d", i), 32'(last_wr), 32'(ew));
            if (i > 0) chk($sformatf("R1 length vec%0d", i), 32'(last_len), 32'(el));
            if (op == 8'h22) begin
                chk($sformatf("R4 low byte vec%0d", i), 32'(mem[mix(a)]), 32'(exp_l));
                chk($sformatf("R5 high byte vec%0d", i), 32'(mem[mix(a + 16'd1)]), 32'(exp_h));
            end
        end

        // R2/R5: PC wraps during operand fetch on the second instance.
        mem[mix(16'hFFFE)] = 8'h2A;
        mem[mix(16'hFFFF)] = 8'h10;
        mem[mix(16'h0000)] = 8'h81;
        mem[mix(16'h8110)] = 8'hC3;
        mem[mix(16'h8111)] = 8'h3C;
        @(negedge clk);
        chk("R9 u1 reset pc", 32'(pc1), 32'hFFFE);
        rst1_n = 1'b1;
        wait_done(1);
        chk("R2 pc wrap", 32'(pc1), 32'h0001);
        chk("R3 l after wrap", 32'(reg_l1), 32'hC3);
        chk("R3 h after wrap", 32'(reg_h1), 32'h3C);

        // R9: reset in the middle of a run, then R1 unknown opcode at 0x0000.
        rst_n = 1'b0;
        mem[mix(16'h0000)] = 8'h5A;
        repeat (2) @(negedge clk);
        chk("R9 mid pc", 32'(pc), 32'h0000);
        chk("R9 mid pair", {16'd0, reg_h, reg_l}, 32'h0000);
        chk("R9 mid strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        wait_done(0);
        chk("R1 unknown opcode pc", 32'(pc), 32'h0001);
        chk("R1 unknown opcode reads", 32'(last_rd), 32'd1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule